// File: doc/BRIEF.md
# Programmable Phase Clock Pattern Generator

This block derives three modulation clocks from a single fast root clock: two pixel clocks (A and B) that are normally driven in antiphase, and a light-source clock whose phase offset against them can be set freely. Since all three are timed by the same root clock, their frequency and their relative phase are exact. A period counter sets how many root cycles one output period lasts. Each output has its own rising-edge counter and falling-edge counter. Each counter fires once per period at a programmed root-cycle index, and this pulse sets or clears that output's level. Any edge can be pushed back by half a root period through the opposite phase of the root clock. Edge placement therefore has a resolution of half a root period.

All counters are maximal-length LFSRs with a fixed terminal state of 1. Software never writes a count directly. It writes the LFSR state that reaches the terminal state after the wanted number of steps. A controller writes these values into shadow registers through a simple write port. Each output period begins with a restart, and the shadow values become active only at that restart. Frequency and phase can therefore be changed between captures, or even mid-run, without a runt pulse. While the enable input is low, all outputs are held low and the counters wait at index 0.

Top module: `phase_clk_gen`

## Requirements
- R1: After reset, every output is low, every shadow value selects index 0, and every half flag is clear. Enabling with this default setting leaves all outputs low, because each output's rise and fall then collide at index 0.
- R2: The LFSR uses the polynomial x^16+x^15+x^13+x^4+1, shifting left with the feedback in bit 0 and a terminal state of 1. If the period value is the state that reaches 1 after N-1 steps, the output period is N root cycles.
- R3: If an edge value reaches 1 after k steps, that edge lands k+1 root cycles after the start of its period. On the first enabled period, the period starts at the first rising root edge after enable goes high. Pulse width and the phase between outputs follow from the differences of these indices.
- R4: Bit W of the write data (bit 16 by default) is the half flag. When it is set, that edge moves half a root period later.
- R5: If a rise and a fall of one output hit in the same root cycle and neither has its half flag set, the fall wins and the output stays low.
- R6: If a full-cycle rise and a half-delayed fall hit in the same root cycle, the output is high for exactly half a root period.
- R7: Write select codes are: 0 = period, 1 = A rise, 2 = A fall, 3 = B rise, 4 = B fall, 5 = light rise, 6 = light fall. Code 7 changes nothing.
- R8: A write made during a period does not change that period. It takes effect from the next period start.
- R9: While enable is low, all outputs are low from one root cycle after it drops. When enable rises again, the next period starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p | input | 1 | Root clock, main phase |
| clk_n | input | 1 | Root clock, opposite phase (used for half-period edges) |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low holds the outputs low |
| cfg_we | input | 1 | Write strobe for a shadow register |
| cfg_sel | input | 3 | Shadow register select (R7) |
| cfg_data | input | W+1 | Bit W is the half flag; bits W-1:0 are the LFSR preload |
| pix_a | output | 1 | Pixel modulation clock A |
| pix_b | output | 1 | Pixel modulation clock B |
| light_mod | output | 1 | Light-source modulation clock |

## Verification
The rising and falling edge counters of one output can fire in the same root cycle. The bench provokes this on purpose: it places both edges of output A at the same index with full-cycle timing, and both edges of output B at the same index with only the fall half-delayed. It then samples both half-periods of every root cycle to judge the result. The expected results are that A never goes high and that B shows a single half-period pulse once per period. The checker judges the same collisions cycle by cycle from the counter hit signals.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
   localparam int unsigned NCH  = 3;
   localparam int unsigned NE   = 2 * NCH;
   localparam int unsigned SELW = $clog2(NE + 1);

   // Feedback taps for supported LFSR widths (maximal length)
   function automatic logic [15:0] taps_for(input int unsigned w);
      return (w == 8) ? 16'h00B8 : 16'hD008;
   endfunction
endpackage

// File: rtl/pcg_lfsr.sv
module pcg_lfsr #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         hit
);
   localparam logic [15:0]  TAPS16 = pcg_pkg::taps_for(W);
   localparam logic [W-1:0] MASK   = TAPS16[W-1:0];
   localparam logic [W-1:0] TERM   = W'(1);

   logic [W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st <= TERM;
      else if (load) st <= load_val;
      else           st <= {st[W-2:0], ^(st & MASK)};
   end

   assign hit = (st == TERM);
endmodule

// File: rtl/pcg_chan.sv
module pcg_chan (
   input  logic clk_p,
   input  logic clk_n,
   input  logic rst_n,
   input  logic en,
   input  logic rise_hit,
   input  logic fall_hit,
   input  logic rise_half,
   input  logic fall_half,
   output logic q
);
   logic lvl, p, n, first, second;

   // Ordered resolution: full-cycle events, then half-delayed ones; fall wins
   always_comb begin
      first = lvl;
      if (rise_hit && !rise_half) first = 1'b1;
      if (fall_hit && !fall_half) first = 1'b0;
      second = first;
      if (rise_hit && rise_half) second = 1'b1;
      if (fall_hit && fall_half) second = 1'b0;
      if (!en) begin
         first  = 1'b0;
         second = 1'b0;
      end
   end

   always_ff @(posedge clk_p or negedge rst_n) begin
      if (!rst_n) begin
         lvl <= 1'b0;
         p   <= 1'b0;
      end else begin
         lvl <= second;
         p   <= first ^ n;
      end
   end

   always_ff @(posedge clk_n or negedge rst_n) begin
      if (!rst_n) n <= 1'b0;
      else        n <= lvl ^ p;
   end

   assign q = p ^ n;
endmodule

// File: rtl/phase_clk_gen.sv
module phase_clk_gen #(
   parameter int unsigned W = 16
) (
   input  logic                      clk_p,
   input  logic                      clk_n,
   input  logic                      rst_n,
   input  logic                      enable,
   input  logic                      cfg_we,
   input  logic [pcg_pkg::SELW-1:0]  cfg_sel,
   input  logic [W:0]                cfg_data,
   output logic                      pix_a,
   output logic                      pix_b,
   output logic                      light_mod
);
   import pcg_pkg::*;

   localparam logic [W-1:0] TERM = W'(1);

   generate
      if (!(W == 8 || W == 16)) begin : g_bad_w
         $error("phase_clk_gen: W must be 8 or 16");
      end
   endgenerate

   logic [W-1:0]   shd_cnt;
   logic [W-1:0]   shd_edge [NE];
   logic [NE-1:0]  shd_half;
   logic [NE-1:0]  act_half;
   logic [NE-1:0]  e_hit;
   logic [NCH-1:0] clk_vec;
   logic           cyc_hit;
   logic           restart;

   always_ff @(posedge clk_p or negedge rst_n) begin
      if (!rst_n) begin
         shd_cnt  <= TERM;
         shd_half <= '0;
         for (int i = 0; i < NE; i++) shd_edge[i] <= TERM;
      end else if (cfg_we) begin
         if (cfg_sel == '0) shd_cnt <= cfg_data[W-1:0];
         for (int i = 0; i < NE; i++) begin
            if (cfg_sel == SELW'(i + 1)) begin
               shd_edge[i] <= cfg_data[W-1:0];
               shd_half[i] <= cfg_data[W];
            end
         end
      end
   end

   assign restart = ~enable | cyc_hit;

   always_ff @(posedge clk_p or negedge rst_n) begin
      if (!rst_n)       act_half <= '0;
      else if (restart) act_half <= shd_half;
   end

   pcg_lfsr #(.W(W)) u_cyc (
      .clk(clk_p), .rst_n(rst_n), .load(restart),
      .load_val(shd_cnt), .hit(cyc_hit)
   );

   generate
      for (genvar e = 0; e < NE; e++) begin : g_edge
         pcg_lfsr #(.W(W)) u_edge (
            .clk(clk_p), .rst_n(rst_n), .load(restart),
            .load_val(shd_edge[e]), .hit(e_hit[e])
         );
      end
      for (genvar c = 0; c < NCH; c++) begin : g_chan
         pcg_chan u_ch (
            .clk_p(clk_p), .clk_n(clk_n), .rst_n(rst_n), .en(enable),
            .rise_hit(e_hit[2*c]), .fall_hit(e_hit[2*c+1]),
            .rise_half(act_half[2*c]), .fall_half(act_half[2*c+1]),
            .q(clk_vec[c])
         );
      end
   endgenerate

   assign pix_a     = clk_vec[0];
   assign pix_b     = clk_vec[1];
   assign light_mod = clk_vec[2];
endmodule

// File: rtl/pcg_chk.sv
module pcg_chk (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       enable,
   input logic [pcg_pkg::NE-1:0]     hit,
   input logic [pcg_pkg::NE-1:0]     half,
   input logic [pcg_pkg::NCH-1:0]    q
);
   // R9
   disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(enable) |-> (q == '0));

   generate
      for (genvar c = 0; c < pcg_pkg::NCH; c++) begin : g_c
         // R3
         rise_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(enable && hit[2*c] && !half[2*c] && !hit[2*c+1]) |-> q[c]);
         // R4
         rise_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(enable && hit[2*c] && half[2*c] && !hit[2*c+1]) |-> q[c]);
         // R5
         collide_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(enable && hit[2*c] && !half[2*c] && hit[2*c+1] && !half[2*c+1]) |-> !q[c]);
         // R6
         collide_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(enable && hit[2*c] && !half[2*c] && hit[2*c+1] && half[2*c+1]) |-> !q[c]);
      end
   endgenerate
endmodule

bind phase_clk_gen pcg_chk u_chk (
   .clk(clk_p), .rst_n(rst_n), .enable(enable),
   .hit(e_hit), .half(act_half), .q(clk_vec)
);

// File: tb/tb_phase_clk_gen.sv
`timescale 1ns/1ps
module tb_phase_clk_gen;
   localparam int W = 16;
   localparam int M = 65535;

   logic clk_p = 1'b0;
   logic clk_n;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_sel = '0;
   logic [W:0] cfg_data = '0;
   logic pix_a, pix_b, light_mod;

   int total = 0;
   int bad = 0;
   logic [2:0] sl [0:255];

   always #2.5 clk_p = ~clk_p;
   assign clk_n = ~clk_p;

   phase_clk_gen #(.W(W)) dut (
      .clk_p(clk_p), .clk_n(clk_n), .rst_n(rst_n), .enable(enable),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .pix_a(pix_a), .pix_b(pix_b), .light_mod(light_mod)
   );

   function automatic logic [15:0] lstep(input logic [15:0] s);
      return {s[14:0], ^(s & 16'hD008)};
   endfunction

   // State that reaches 1 after k steps
   function automatic logic [15:0] pre(input int k);
      logic [15:0] s = 16'h0001;
      for (int i = 0; i < M - k; i++) s = lstep(s);
      return s;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int sel, input bit half, input int k);
      @(posedge clk_p); #1;
      cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = {half, pre(k)};
      @(posedge clk_p); #1;
      cfg_we = 1'b0;
   endtask

   task automatic start_run();
      @(posedge clk_p); #1;
      enable = 1'b1;
   endtask

   task automatic stop_run();
      @(posedge clk_p); #1;
      enable = 1'b0;
      repeat (2) @(posedge clk_p);
   endtask

   // slot 2i = first half of root cycle i after enable, 2i+1 = second half
   task automatic capture(input int ncyc);
      #0.25; sl[0] = {light_mod, pix_b, pix_a};
      @(negedge clk_p); #1.25; sl[1] = {light_mod, pix_b, pix_a};
      for (int i = 1; i < ncyc; i++) begin
         @(posedge clk_p); #1.25; sl[2*i] = {light_mod, pix_b, pix_a};
         @(negedge clk_p); #1.25; sl[2*i+1] = {light_mod, pix_b, pix_a};
      end
   endtask

   function automatic int find_edge(input int ch, input int from, input bit v);
      for (int i = from; i < 256; i++) begin
         if (sl[i][ch] == v && (i == 0 ? 1'b0 : sl[i-1][ch]) != v) return i;
      end
      return -1;
   endfunction

   function automatic int high_count(input int ch, input int from, input int to);
      int cnt = 0;
      for (int i = from; i < to; i++) if (sl[i][ch]) cnt++;
      return cnt;
   endfunction

   task automatic t_reset();
      chk("R1 reset pix_a", int'(pix_a), 0);
      chk("R1 reset pix_b", int'(pix_b), 0);
      chk("R1 reset light", int'(light_mod), 0);
      start_run();
      capture(20);
      chk("R1 default config stays low", high_count(0, 0, 40) + high_count(1, 0, 40)
          + high_count(2, 0, 40), 0);
      stop_run();
   endtask

   task automatic t_basic();
      int ra, fa, eq;
      wr(0, 0, 9);  wr(1, 0, 0); wr(2, 0, 5);
      wr(3, 0, 5);  wr(4, 0, 0); wr(5, 1, 2); wr(6, 1, 7);
      start_run();
      capture(30);
      ra = find_edge(0, 0, 1);
      fa = find_edge(0, ra, 0);
      chk("R3 A first rise slot", ra, 2);
      chk("R3 A high width", fa - ra, 10);
      chk("R2 A period slots", find_edge(0, fa, 1) - ra, 20);
      chk("R3 B rise slot", find_edge(1, 0, 1), 12);
      chk("R4 light half rise slot", find_edge(2, 0, 1), 7);
      chk("R4 light half fall slot", find_edge(2, 8, 0), 17);
      eq = 0;
      for (int i = 2; i < 60; i++) if (sl[i][0] == sl[i][1]) eq++;
      chk("R3 A and B antiphase", eq, 0);
      stop_run();
   endtask

   task automatic t_collide();
      int rb;
      wr(0, 0, 7);  wr(1, 0, 3); wr(2, 0, 3);
      wr(3, 0, 3);  wr(4, 1, 3); wr(5, 0, 0); wr(6, 0, 4);
      start_run();
      capture(24);
      chk("R5 A full collision never high", high_count(0, 0, 48), 0);
      rb = find_edge(1, 0, 1);
      chk("R6 B half pulse rise", rb, 8);
      chk("R6 B half pulse fall", find_edge(1, rb, 0), 9);
      chk("R6 B half pulse repeats", find_edge(1, 10, 1), 24);
      stop_run();
   endtask

   task automatic t_update();
      int r;
      wr(0, 0, 9); wr(1, 0, 0); wr(2, 0, 5);
      start_run();
      fork
         capture(50);
         begin
            repeat (11) @(posedge clk_p);
            wr(7, 1, 1);
            repeat (8) @(posedge clk_p);
            wr(0, 0, 5);
            wr(2, 0, 3);
         end
      join
      chk("R7 select 7 ignored rise", find_edge(0, 3, 1), 22);
      chk("R7 select 7 ignored width", find_edge(0, 22, 0) - 22, 10);
      r = find_edge(0, 23, 1);
      chk("R8 period in progress keeps rise", r, 42);
      chk("R8 period in progress keeps width", find_edge(0, r, 0) - r, 10);
      r = find_edge(0, r + 1, 1);
      chk("R8 new config rise", r, 62);
      chk("R8 new width", find_edge(0, r, 0) - r, 6);
      chk("R2 new period slots", find_edge(0, r + 1, 1) - r, 12);
      stop_run();
   endtask

   task automatic t_disable();
      wr(0, 0, 9); wr(1, 0, 0); wr(2, 0, 5);
      start_run();
      repeat (3) @(posedge clk_p);
      #1.25;
      chk("R9 A high before disable", int'(pix_a), 1);
      enable = 1'b0;
      @(posedge clk_p); #1.25;
      chk("R9 outputs low after disable", int'({light_mod, pix_b, pix_a}), 0);
      repeat (3) @(posedge clk_p);
      chk("R9 still low while disabled", int'({light_mod, pix_b, pix_a}), 0);
      start_run();
      capture(12);
      chk("R9 restart at index 0", find_edge(0, 0, 1), 2);
      stop_run();
   endtask

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk_p);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk_p);
      #1.25;
      t_reset();
      t_basic();
      t_collide();
      t_update();
      t_disable();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule